// File: doc/BRIEF.md
# Triggered Programmable Delay Generator

This block turns one trigger event into up to two precisely timed single-cycle pulses. A rising edge on the chosen trigger source (an on-chip signal or a signal from outside the chip) starts a counter. The counter runs from zero up to a programmable modulo. Two independent compare channels each fire a one-cycle pulse when the count reaches their own delay value. A combined output merges the two channels through a per-channel mask, so one trigger can schedule two downstream events on a single line.

The counter either makes a single pass and then waits for the next trigger, or it wraps at the modulo and repeats for as long as the block stays enabled. In bypass mode the counter is held idle and the selected trigger level is passed to the outputs with only the output register in the path. Pulling the enable input low parks the counter and clears every output. All inputs are assumed to be synchronous to `clk`.

Top module: `trig_delay_gen`

## Requirements
- R1: While `rst` is high on a clock edge, `pulse_a`, `pulse_b` and `or_out` are low after that edge, and the counter is idle.
- R2: `trig_sel` = 0 selects `trig_int` and `trig_sel` = 1 selects `trig_ext`. Edges on the unselected source have no effect on any output.
- R3: Call edge k the clock edge at which the selected trigger is sampled high after being low in the previous sample, with the counter idle. Then `pulse_a` is high for exactly one cycle, in the cycle after edge k+1+`delay_a`.
- R4: `pulse_b` follows the same timing as R3, using `delay_b`. It does so independently of channel A.
- R5: `or_out` is high exactly when (`pulse_a` AND `or_mask[0]`) OR (`pulse_b` AND `or_mask[1]`), with the mask sampled in the same cycle as the pulse sources.
- R6: A channel whose delay is greater than `modulo` never pulses.
- R7: With `continuous` = 0, the counter makes one pass through counts 0..`modulo` and then goes idle. Trigger edges that arrive during the pass are ignored.
- R8: With `continuous` = 1, the counter wraps from `modulo` to 0. Each channel then pulses every `modulo`+1 cycles until the block is disabled or bypassed.
- R9: With `bypass` = 1 (and `enable` = 1), `pulse_a` and `pulse_b` equal the selected trigger level one clock later. `or_out` applies the mask from R5 to those values, and the counter stays idle.
- R10: With `enable` = 0, the counter is held idle at zero and all outputs are low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low holds the counter idle and clears outputs |
| trig_int | input | 1 | On-chip trigger source |
| trig_ext | input | 1 | Off-chip trigger source |
| trig_sel | input | 1 | Source select: 0 on-chip, 1 off-chip |
| continuous | input | 1 | 1 = wrap and repeat, 0 = single pass |
| bypass | input | 1 | 1 = pass the trigger level straight to the outputs |
| modulo | input | CNT_W | Terminal count of each pass |
| delay_a | input | CNT_W | Compare value for channel A |
| delay_b | input | CNT_W | Compare value for channel B |
| or_mask | input | 2 | Bit 0 admits channel A and bit 1 admits channel B to `or_out` |
| pulse_a | output | 1 | Channel A pulse (registered) |
| pulse_b | output | 1 | Channel B pulse (registered) |
| or_out | output | 1 | Masked OR of both channels (registered) |

## Verification
The bench builds the block with `CNT_W` = 6. This keeps the modulo range small enough that a pass at the largest modulo (63), with a delay at that same terminal count, finishes in a few dozen cycles. Random modulo and delay values are drawn mostly below 16, so that continuous runs wrap several times within each observation window. Some draws place a delay above the modulo. Directed cases cover a zero modulo, a zero delay, retriggering during a pass, source selection, bypass, and disabling during a run.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} tdg_src_e;
  localparam int unsigned TDG_CHANNELS = 2;
endpackage

// File: rtl/tdg_edge.sv
module tdg_edge
  import tdg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_int,
  input  logic trig_ext,
  input  logic trig_sel,
  output logic level,
  output logic rise
);
  logic level_q;

  always_comb begin
    level = (tdg_src_e'(trig_sel) == SRC_EXT) ? trig_ext : trig_int;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/tdg_counter.sv
module tdg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             bypass,
  input  logic             start,
  input  logic             continuous,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !enable || bypass) begin
      running <= 1'b0;
      count   <= '0;
    end else if (running) begin
      if (count >= modulo) begin
        count <= '0;
        if (!continuous) running <= 1'b0;
      end else begin
        count <= count + ONE;
      end
    end else if (start) begin
      running <= 1'b1;
      count   <= '0;
    end
  end
endmodule

// File: rtl/tdg_match.sv
module tdg_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             enable,
  input  logic             bypass,
  input  logic             level,
  input  logic             running,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] modulo,
  input  logic [CNT_W-1:0] delay,
  output logic             hit
);
  always_comb begin
    if (!enable)     hit = 1'b0;
    else if (bypass) hit = level;
    else             hit = running && (count == delay) && (count <= modulo);
  end
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen
  import tdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             trig_int,
  input  logic             trig_ext,
  input  logic             trig_sel,
  input  logic             continuous,
  input  logic             bypass,
  input  logic [CNT_W-1:0] modulo,
  input  logic [CNT_W-1:0] delay_a,
  input  logic [CNT_W-1:0] delay_b,
  input  logic [1:0]       or_mask,
  output logic             pulse_a,
  output logic             pulse_b,
  output logic             or_out
);
  logic                         level;
  logic                         rise;
  logic [CNT_W-1:0]             count;
  logic                         running;
  logic [CNT_W-1:0]             dly [TDG_CHANNELS];
  logic [TDG_CHANNELS-1:0]      hit;
  logic [TDG_CHANNELS-1:0]      pulse_q;
  logic                         or_q;

  assign dly[0] = delay_a;
  assign dly[1] = delay_b;

  tdg_edge u_edge (
    .clk(clk), .rst(rst), .trig_int(trig_int), .trig_ext(trig_ext),
    .trig_sel(trig_sel), .level(level), .rise(rise)
  );

  tdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .bypass(bypass), .start(rise),
    .continuous(continuous), .modulo(modulo), .count(count), .running(running)
  );

  for (genvar i = 0; i < TDG_CHANNELS; i++) begin : g_ch
    tdg_match #(.CNT_W(CNT_W)) u_match (
      .enable(enable), .bypass(bypass), .level(level), .running(running),
      .count(count), .modulo(modulo), .delay(dly[i]), .hit(hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
      or_q    <= 1'b0;
    end else begin
      pulse_q <= hit;
      or_q    <= |(hit & or_mask);
    end
  end

  assign pulse_a = pulse_q[0];
  assign pulse_b = pulse_q[1];
  assign or_out  = or_q;
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             trig_int,
  input logic             trig_ext,
  input logic             trig_sel,
  input logic             bypass,
  input logic [CNT_W-1:0] modulo,
  input logic [CNT_W-1:0] delay_a,
  input logic [CNT_W-1:0] delay_b,
  input logic             pulse_a,
  input logic             pulse_b,
  input logic             or_out
);
  // R10
  enable_low_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pulse_a && !pulse_b && !or_out));

  // R6
  late_a_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_a && !$past(bypass)) |-> ($past(delay_a) <= $past(modulo)));

  // R6
  late_b_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_b && !$past(bypass)) |-> ($past(delay_b) <= $past(modulo)));

  // R5
  or_src_chk: assert property (@(posedge clk) disable iff (rst)
    or_out |-> (pulse_a || pulse_b));

  // R9
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(enable) && $past(bypass)) |->
      (pulse_a == $past(trig_sel ? trig_ext : trig_int)) &&
      (pulse_b == $past(trig_sel ? trig_ext : trig_int)));

  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_a && !pulse_b && !or_out));
endmodule

bind trig_delay_gen tdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .trig_int(trig_int),
  .trig_ext(trig_ext), .trig_sel(trig_sel), .bypass(bypass),
  .modulo(modulo), .delay_a(delay_a), .delay_b(delay_b),
  .pulse_a(pulse_a), .pulse_b(pulse_b), .or_out(or_out)
);

// File: tb/sim_trig_delay_gen.sv
module sim_trig_delay_gen;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst, enable, trig_int, trig_ext, trig_sel, continuous, bypass;
  logic [W-1:0] modulo, delay_a, delay_b;
  logic [1:0] or_mask;
  logic pulse_a, pulse_b, or_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_delay_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .trig_int(trig_int),
    .trig_ext(trig_ext), .trig_sel(trig_sel), .continuous(continuous),
    .bypass(bypass), .modulo(modulo), .delay_a(delay_a), .delay_b(delay_b),
    .or_mask(or_mask), .pulse_a(pulse_a), .pulse_b(pulse_b), .or_out(or_out)
  );

  function automatic bit exp_pulse(int t, int d, int m, bit cont);
    if (t < 1 || d > m) return 1'b0;
    if (!cont) return (t - 1) == d;
    return ((t - 1) % (m + 1)) == d;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_reset();
    @(negedge clk); enable = 1'b0; trig_int = 1'b0; trig_ext = 1'b0;
    @(negedge clk); @(negedge clk); enable = 1'b1;
    @(negedge clk);
  endtask

  // Fires one trigger on the selected source, observes a window and
  // counts mismatches per output against the expected schedule.
  task automatic run(string tag, int m, int da, int db, bit cont,
                     bit fire_sel, logic [1:0] mask, bit retrig);
    int len, ea, eb, eo, bad_a, bad_b, bad_o;
    modulo = W'(m); delay_a = W'(da); delay_b = W'(db);
    continuous = cont; or_mask = mask; bypass = 1'b0;
    idle_reset();
    if (fire_sel) trig_ext = 1'b1; else trig_int = 1'b1;
    @(negedge clk);
    trig_int = 1'b0; trig_ext = 1'b0;
    len = cont ? 3 * (m + 1) + 2 : m + 6;
    bad_a = 0; bad_b = 0; bad_o = 0;
    for (int t = 0; t <= len; t++) begin
      if (t > 0) @(negedge clk);
      ea = (fire_sel == trig_sel) ? exp_pulse(t, da, m, cont) : 0;
      eb = (fire_sel == trig_sel) ? exp_pulse(t, db, m, cont) : 0;
      eo = (ea & mask[0]) | (eb & mask[1]);
      if (pulse_a != ea[0]) bad_a++;
      if (pulse_b != eb[0]) bad_b++;
      if (or_out != eo[0]) bad_o++;
      if (retrig && t == 2) trig_int = 1'b1;
      if (retrig && t == 3) trig_int = 1'b0;
    end
    check({tag, " R3 chan A mismatches"}, bad_a, 0);
    check({tag, " R4 chan B mismatches"}, bad_b, 0);
    check({tag, " R5 or_out mismatches"}, bad_o, 0);
  endtask

  initial begin
    int seed, m, da, db;
    seed = $urandom(32'h5EED_1234);
    rst = 1'b1; enable = 1'b0; trig_int = 1'b0; trig_ext = 1'b0;
    trig_sel = 1'b0; continuous = 1'b0; bypass = 1'b0;
    modulo = '0; delay_a = '0; delay_b = '0; or_mask = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 reset pulse_a", pulse_a, 0);
    check("R1 reset pulse_b", pulse_b, 0);
    check("R1 reset or_out", or_out, 0);
    rst = 1'b0; enable = 1'b1;

    // R3 R4 R7 single pass, zero and terminal delays
    run("R7 single", 7, 0, 7, 1'b0, 1'b0, 2'b11, 1'b0);
    // R7 retrigger during pass ignored
    run("R7 retrig", 9, 3, 6, 1'b0, 1'b0, 2'b01, 1'b1);
    // R8 continuous with zero modulo and normal wrap
    run("R8 cont m0", 0, 0, 0, 1'b1, 1'b0, 2'b10, 1'b0);
    run("R8 cont", 5, 2, 4, 1'b1, 1'b0, 2'b11, 1'b0);
    // R6 delay beyond modulo
    run("R6 late", 4, 5, 2, 1'b1, 1'b0, 2'b11, 1'b0);
    // R3 largest modulo
    run("R3 maxmod", MAXV, MAXV, 1, 1'b0, 1'b0, 2'b11, 1'b0);
    // R2 source select: external selected, internal ignored, then external fires
    trig_sel = 1'b1;
    run("R2 unselected", 3, 1, 2, 1'b0, 1'b0, 2'b11, 1'b0);
    run("R2 external", 3, 1, 2, 1'b0, 1'b1, 2'b11, 1'b0);
    trig_sel = 1'b0;

    // random runs
    for (int i = 0; i < 20; i++) begin
      m  = (i % 4 == 0) ? int'($urandom_range(MAXV)) : int'($urandom_range(15));
      da = int'($urandom_range(m + 2 > MAXV ? MAXV : m + 2));
      db = int'($urandom_range(m + 2 > MAXV ? MAXV : m + 2));
      run("rand", m, da, db, 1'($urandom_range(1)), 1'b0,
          2'($urandom_range(3)), 1'b0);
    end

    // R9 bypass follows selected level one cycle later
    idle_reset();
    bypass = 1'b1; or_mask = 2'b10; trig_sel = 1'b0;
    trig_int = 1'b1;
    @(negedge clk);
    check("R9 bypass pulse_a high", pulse_a, 1);
    check("R9 bypass pulse_b high", pulse_b, 1);
    check("R9 bypass or_out", or_out, 1);
    @(negedge clk);
    check("R9 bypass held level", pulse_a, 1);
    trig_int = 1'b0;
    @(negedge clk);
    check("R9 bypass low", pulse_b, 0);
    bypass = 1'b0;

    // R10 disable mid-run in continuous mode
    modulo = W'(3); delay_a = '0; delay_b = W'(1); continuous = 1'b1;
    or_mask = 2'b11;
    idle_reset();
    trig_int = 1'b1; @(negedge clk); trig_int = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    begin
      int hits = 0;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        hits += pulse_a + pulse_b + or_out;
      end
      check("R10 outputs low while disabled", hits, 0);
    end
    enable = 1'b1;
    begin
      int hits = 0;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        hits += pulse_a + pulse_b;
      end
      check("R10 counter idle after re-enable", hits, 0);
    end

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule